// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio N and emits one single-cycle pulse per N input clocks toward a phase detector. It runs a dual-modulus prescaler, P or P+1, whose modulus is steered by a swallow counter A. A main counter B counts prescaler periods and sets the length of each output period. The prescaler spends A periods at P+1 and the remaining B−A periods at P, so N = B·P + A. The prescaler is built as synchronous logic in the same clock domain as the counters.

A configuration strobe captures a new modulus select, A and B into a holding stage. The divider adopts those values only at the next output-period boundary, so no output period mixes two settings. A setting that breaks the counter rules is flagged and never adopted, and the divider keeps its last good ratio.

Top module: `swallow_divider`

## Requirements
- R1: The spacing between consecutive rising edges of `div_pulse` is exactly B·P + A input clocks, and it repeats unchanged while the configuration is unchanged.
- R2: `mode_sel` picks the modulus pair: 0 gives 8/9, 1 gives 16/17, 2 gives 32/33 and 3 gives 64/65.
- R3: `div_pulse` is high for exactly one input clock per period. It rises in the cycle after the main counter wraps.
- R4: Values captured while `load` is high take effect at the next period boundary. The period already in progress completes with the old ratio.
- R5: `cfg_ok` is 1 exactly when the most recently captured values satisfy B ≥ A and B ≥ 3. A captured set that fails this test is never adopted, and the previous ratio continues.
- R6: A synchronous reset (`rst` high at a clock edge) forces `div_pulse` low and `cfg_ok` high. It restores mode 0, A = 0 and B = 3 (N = 24), and the first pulse rises exactly 24 clocks after the last reset edge.
- R7: Within each period the prescaler runs at P+1 for the first A prescaler periods and at P afterwards. A = 0 therefore gives B·P, and A = B gives B·(P+1).
- R8: The full field range is accepted: A up to 63 (6 bits) and B up to 8191 (13 bits). With mode 0, A = 63 and B = 8191 the period is 65591 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for the three configuration fields |
| mode_sel | input | 2 | Modulus pair select (0: 8/9, 1: 16/17, 2: 32/33, 3: 64/65) |
| sw_val | input | 6 | Swallow count A |
| main_val | input | 13 | Main count B |
| div_pulse | output | 1 | One-clock pulse per N input clocks |
| cfg_ok | output | 1 | Most recently captured configuration is usable |

## Verification
The bench measures pulse spacing for every modulus pair. This includes the edge settings A = 0, A = B, B = 3 and the largest B, where a wrong swallow count or an off-by-one wrap shifts the period by one or more prescaler lengths. It loads new values shortly after a pulse and measures the period still running. A design that applied the values at once would show a mixed length there instead of the old N. It loads settings with B < A and B = 2, which a careless design would adopt and then wrap wrongly or stall. It also resets in the middle of a long period, where a design that failed to clear its holding stage or counters would misplace the first pulse.

// File: rtl/sd_pkg.sv
package sd_pkg;

   // Prescaler base modulus P for a given mode index: P = 2^(base_log2 + mode)
   function automatic int unsigned modulus_of(int unsigned base_log2, int unsigned mode);
      return 32'd1 << (base_log2 + mode);
   endfunction

   // Smallest legal main count; a lower value leaves no room for a wrap cycle
   localparam int unsigned MIN_MAIN = 3;

endpackage

// File: rtl/sd_cfg_stage.sv
module sd_cfg_stage #(
   parameter int A_W    = 6,
   parameter int B_W    = 13,
   parameter int MODE_W = 2,
   parameter logic [A_W-1:0]    RST_A    = '0,
   parameter logic [B_W-1:0]    RST_B    = 3,
   parameter logic [MODE_W-1:0] RST_MODE = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [MODE_W-1:0] mode_in,
   input  logic [A_W-1:0]    a_in,
   input  logic [B_W-1:0]    b_in,
   input  logic              boundary,
   output logic [MODE_W-1:0] act_mode,
   output logic [A_W-1:0]    act_a,
   output logic [B_W-1:0]    act_b,
   output logic [MODE_W-1:0] nxt_mode,
   output logic [A_W-1:0]    nxt_a,
   output logic [B_W-1:0]    nxt_b,
   output logic              pend_ok
);
   import sd_pkg::*;

   if (B_W < A_W) begin : g_bad_width
      $error("sd_cfg_stage: B_W must be at least A_W");
   end
   if ((int'(RST_B) < int'(MIN_MAIN)) || (int'(RST_B) < int'(RST_A))) begin : g_bad_reset
      $error("sd_cfg_stage: reset configuration violates the counter rules");
   end

   logic [MODE_W-1:0] pend_mode;
   logic [A_W-1:0]    pend_a;
   logic [B_W-1:0]    pend_b;
   logic              adopt;

   // holding stage written by the strobe
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_mode <= RST_MODE;
         pend_a    <= RST_A;
         pend_b    <= RST_B;
      end else if (load) begin
         pend_mode <= mode_in;
         pend_a    <= a_in;
         pend_b    <= b_in;
      end
   end

   assign pend_ok = (pend_b >= B_W'(pend_a)) && (pend_b >= B_W'(MIN_MAIN));
   assign adopt   = boundary && pend_ok;

   assign nxt_mode = adopt ? pend_mode : act_mode;
   assign nxt_a    = adopt ? pend_a    : act_a;
   assign nxt_b    = adopt ? pend_b    : act_b;

   // active set, only ever replaced at a period boundary
   always_ff @(posedge clk) begin
      if (rst) begin
         act_mode <= RST_MODE;
         act_a    <= RST_A;
         act_b    <= RST_B;
      end else begin
         act_mode <= nxt_mode;
         act_a    <= nxt_a;
         act_b    <= nxt_b;
      end
   end

   assert_hold_midperiod_R4: assert property (@(posedge clk) disable iff (rst)
      !boundary |=> ($stable(act_mode) && $stable(act_a) && $stable(act_b)));

   assert_reject_bad_R5: assert property (@(posedge clk) disable iff (rst)
      (boundary && !pend_ok) |=> ($stable(act_mode) && $stable(act_a) && $stable(act_b)));

   assert_active_legal_R5: assert property (@(posedge clk) disable iff (rst)
      (act_b >= B_W'(act_a)) && (act_b >= B_W'(MIN_MAIN)));

endmodule

// File: rtl/sd_prescaler.sv
module sd_prescaler #(
   parameter int MODE_W    = 2,
   parameter int BASE_LOG2 = 3,
   localparam int PC_W     = BASE_LOG2 + (1 << MODE_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] mode,
   input  logic              swallow,
   output logic              tc
);
   import sd_pkg::*;

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("sd_prescaler: BASE_LOG2 must be at least 1");
   end

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] p_val;
   logic [PC_W-1:0] last_val;

   assign p_val    = PC_W'(modulus_of(BASE_LOG2, int'(mode)));
   // P+1 while swallowing, otherwise P: last count index is P or P-1
   assign last_val = swallow ? p_val : p_val - PC_W'(1);
   assign tc       = (pc == last_val);

   always_ff @(posedge clk) begin
      if (rst)     pc <= '0;
      else if (tc) pc <= '0;
      else         pc <= pc + PC_W'(1);
   end

   assert_mode_steady_R4: assert property (@(posedge clk) disable iff (rst)
      !tc |=> $stable(mode));

   assert_swallow_steady_R7: assert property (@(posedge clk) disable iff (rst)
      !tc |=> $stable(swallow));

endmodule

// File: rtl/sd_period_ctr.sv
module sd_period_ctr #(
   parameter int A_W = 6,
   parameter int B_W = 13,
   parameter logic [A_W-1:0] RST_A = '0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tc,
   input  logic [A_W-1:0] act_a,
   input  logic [B_W-1:0] act_b,
   input  logic [A_W-1:0] nxt_a,
   output logic           swallow,
   output logic           wrap
);
   logic [A_W-1:0] a_cnt;
   logic [B_W-1:0] b_cnt;
   logic           b_last;

   assign b_last  = (b_cnt == act_b - B_W'(1));
   assign wrap    = tc && b_last;
   assign swallow = (a_cnt != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         a_cnt <= RST_A;
         b_cnt <= '0;
      end else if (tc) begin
         if (b_last) begin
            a_cnt <= nxt_a;
            b_cnt <= '0;
         end else begin
            b_cnt <= b_cnt + B_W'(1);
            if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
         end
      end
   end

   assert_main_in_range_R1: assert property (@(posedge clk) disable iff (rst)
      b_cnt < act_b);

   assert_swallow_track_R7: assert property (@(posedge clk) disable iff (rst)
      (b_cnt <= B_W'(act_a)) |-> ((B_W'(a_cnt) + b_cnt) == B_W'(act_a)));

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
   parameter int A_W       = 6,
   parameter int B_W       = 13,
   parameter int MODE_W    = 2,
   parameter int BASE_LOG2 = 3,
   parameter bit OUT_REG   = 1'b1,
   parameter logic [A_W-1:0]    RST_A    = '0,
   parameter logic [B_W-1:0]    RST_B    = 3,
   parameter logic [MODE_W-1:0] RST_MODE = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic [A_W-1:0]    sw_val,
   input  logic [B_W-1:0]    main_val,
   output logic              div_pulse,
   output logic              cfg_ok
);
   import sd_pkg::*;

   localparam int MIN_N = int'(MIN_MAIN) * (1 << BASE_LOG2);
   localparam int GAP_W = $clog2(MIN_N) + 1;

   logic [MODE_W-1:0] act_mode, nxt_mode;
   logic [A_W-1:0]    act_a, nxt_a;
   logic [B_W-1:0]    act_b, nxt_b;
   logic              tc, swallow, wrap;

   sd_cfg_stage #(
      .A_W(A_W), .B_W(B_W), .MODE_W(MODE_W),
      .RST_A(RST_A), .RST_B(RST_B), .RST_MODE(RST_MODE)
   ) u_cfg (
      .clk(clk), .rst(rst), .load(load),
      .mode_in(mode_sel), .a_in(sw_val), .b_in(main_val),
      .boundary(wrap),
      .act_mode(act_mode), .act_a(act_a), .act_b(act_b),
      .nxt_mode(nxt_mode), .nxt_a(nxt_a), .nxt_b(nxt_b),
      .pend_ok(cfg_ok)
   );

   sd_prescaler #(
      .MODE_W(MODE_W), .BASE_LOG2(BASE_LOG2)
   ) u_pre (
      .clk(clk), .rst(rst), .mode(act_mode), .swallow(swallow), .tc(tc)
   );

   sd_period_ctr #(
      .A_W(A_W), .B_W(B_W), .RST_A(RST_A)
   ) u_ctr (
      .clk(clk), .rst(rst), .tc(tc),
      .act_a(act_a), .act_b(act_b), .nxt_a(nxt_a),
      .swallow(swallow), .wrap(wrap)
   );

   if (OUT_REG) begin : g_out_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (rst) pulse_q <= 1'b0;
         else     pulse_q <= wrap;
      end
      assign div_pulse = pulse_q;
   end else begin : g_out_comb
      assign div_pulse = wrap;
   end

   // checker counter: cycles since the previous pulse, saturating
   logic [GAP_W-1:0] gap_cnt;
   always_ff @(posedge clk) begin
      if (rst)                           gap_cnt <= '0;
      else if (div_pulse)                gap_cnt <= '0;
      else if (gap_cnt != GAP_W'(MIN_N)) gap_cnt <= gap_cnt + GAP_W'(1);
   end

   assert_min_spacing_R1: assert property (@(posedge clk) disable iff (rst)
      div_pulse |-> (gap_cnt >= GAP_W'(MIN_N - 1)));

   assert_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
      div_pulse |=> !div_pulse);

   assert_reset_quiet_R6: assert property (@(posedge clk)
      rst |=> (!div_pulse && cfg_ok));

   assert_nxt_legal_R5: assert property (@(posedge clk) disable iff (rst)
      wrap |-> (nxt_b >= B_W'(nxt_a)));

   assert_mode_range_R2: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(act_mode));

endmodule

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load = 1'b0;
   logic [1:0]  mode_sel = '0;
   logic [5:0]  sw_val = '0;
   logic [12:0] main_val = 13'd3;
   logic        div_pulse;
   logic        cfg_ok;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   localparam int WATCHDOG = 190000;

   // mode, A, B
   localparam int VEC [8][3] = '{
      '{0,  0,  3},
      '{0,  5, 10},
      '{1,  7,  7},
      '{1,  0, 20},
      '{2, 31, 40},
      '{3, 63, 63},
      '{3,  1,  3},
      '{2,  0,  3}
   };

   always #2.5 clk = ~clk;

   swallow_divider u_swallow_divider (
      .clk(clk), .rst(rst), .load(load), .mode_sel(mode_sel),
      .sw_val(sw_val), .main_val(main_val),
      .div_pulse(div_pulse), .cfg_ok(cfg_ok)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG && !done) begin
         done = 1'b1;
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic int ratio(int m, int a, int b);
      return b * (8 << m) + a;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic next_pulse(output int t);
      do @(negedge clk); while (!div_pulse);
      t = cyc;
   endtask

   task automatic load_cfg(int m, int a, int b);
      @(negedge clk);
      load = 1'b1;
      mode_sel = 2'(m);
      sw_val = 6'(a);
      main_val = 13'(b);
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic do_reset(output int tr);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      tr = cyc;
      rst = 1'b0;
   endtask

   initial begin
      int t0, t1, t2, tr, prev_n, n;

      // R6: reset state and default ratio
      repeat (3) @(negedge clk);
      chk(div_pulse == 1'b0, "R6", "pulse low in reset", int'(div_pulse), 0);
      chk(cfg_ok == 1'b1, "R6", "cfg_ok high after reset", int'(cfg_ok), 1);
      tr = cyc;
      rst = 1'b0;
      next_pulse(t0);
      chk(t0 - tr == 24, "R6", "first pulse after reset", t0 - tr, 24);
      prev_n = 24;

      // vector table: R1 period, R2 mode decode, R4 old period kept, R3 width
      for (int i = 0; i < 8; i++) begin
         n = ratio(VEC[i][0], VEC[i][1], VEC[i][2]);
         load_cfg(VEC[i][0], VEC[i][1], VEC[i][2]);
         chk(cfg_ok == 1'b1, "R5", "cfg_ok on legal set", int'(cfg_ok), 1);
         next_pulse(t1);
         chk(t1 - t0 == prev_n, "R4", "period in progress keeps old ratio", t1 - t0, prev_n);
         next_pulse(t2);
         chk(t2 - t1 == n, "R1", "period equals B*P+A", t2 - t1, n);
         chk(t2 - t1 == n, "R2", "modulus pair from mode_sel", t2 - t1, n);
         @(negedge clk);
         chk(div_pulse == 1'b0, "R3", "pulse one clock wide", int'(div_pulse), 0);
         prev_n = n;
         t0 = t2;
      end

      // R5: B < A is flagged and never adopted
      load_cfg(0, 10, 5);
      chk(cfg_ok == 1'b0, "R5", "cfg_ok low for B<A", int'(cfg_ok), 0);
      next_pulse(t1);
      next_pulse(t2);
      chk(t2 - t1 == prev_n, "R5", "ratio unchanged after B<A", t2 - t1, prev_n);
      t0 = t2;

      // R5: B below 3 is flagged and never adopted
      load_cfg(1, 0, 2);
      chk(cfg_ok == 1'b0, "R5", "cfg_ok low for B=2", int'(cfg_ok), 0);
      next_pulse(t1);
      next_pulse(t2);
      chk(t2 - t1 == prev_n, "R5", "ratio unchanged after B=2", t2 - t1, prev_n);
      t0 = t2;

      // R7: A = B, every prescaler period at P+1
      load_cfg(1, 4, 4);
      chk(cfg_ok == 1'b1, "R5", "cfg_ok back high", int'(cfg_ok), 1);
      next_pulse(t1);
      chk(t1 - t0 == prev_n, "R4", "old ratio before adoption", t1 - t0, prev_n);
      next_pulse(t2);
      chk(t2 - t1 == 68, "R7", "A equals B gives B*(P+1)", t2 - t1, 68);
      next_pulse(t0);
      chk(t0 - t2 == 68, "R1", "period repeats", t0 - t2, 68);

      // R6: reset in the middle of a long period restores defaults
      load_cfg(3, 63, 63);
      repeat (40) @(negedge clk);
      do_reset(tr);
      chk(div_pulse == 1'b0, "R6", "pulse low after mid-run reset", int'(div_pulse), 0);
      chk(cfg_ok == 1'b1, "R6", "cfg_ok high after mid-run reset", int'(cfg_ok), 1);
      next_pulse(t0);
      chk(t0 - tr == 24, "R6", "default ratio after mid-run reset", t0 - tr, 24);

      // R8: largest main count with largest swallow count
      load_cfg(0, 63, 8191);
      chk(cfg_ok == 1'b1, "R8", "full range accepted", int'(cfg_ok), 1);
      next_pulse(t1);
      chk(t1 - t0 == 24, "R4", "old ratio before long period", t1 - t0, 24);
      next_pulse(t2);
      chk(t2 - t1 == 65591, "R8", "full range period", t2 - t1, 65591);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule